// File: doc/BRIEF.md
# Masked GPIO Port with Pin and Group Interrupts

This block is one general-purpose I/O port of up to 32 pins, reached through a small single-cycle register bus. Each pin has a direction bit and an output bit. The output bits can be changed in four ways: a full replacement through the data register, a partial replacement through a mask-gated view, or an atomic write-one set, clear or toggle of any subset of bits. Every register takes byte, halfword or word writes. Per-byte strobes choose which bytes change.

Pin inputs pass through a two-stage synchronizer. The synchronized level can always be read back, whether a pin drives or not. Each pin can raise its own interrupt, either on a selected edge or on a selected level. A single group interrupt goes high when any enabled pin, or every enabled pin, sits at its chosen polarity. The pad side is modelled as three vectors: `pin_in`, `pin_out` and `pin_oe`.

Top module: `mgpio_port`

Register offsets are byte addresses on `bus_addr`, word aligned:

| Offset | Register |
|---|---|
| 0x00 | direction |
| 0x04 | mask |
| 0x08 | pin level (read only) |
| 0x0C | masked data |
| 0x10 | data |
| 0x14 | set |
| 0x18 | clear |
| 0x1C | toggle |
| 0x20 | interrupt enable |
| 0x24 | interrupt mode |
| 0x28 | interrupt polarity |
| 0x2C | interrupt status |
| 0x30 | group enable |
| 0x34 | group polarity |
| 0x38 | group control |

## Requirements
- R1: Reset is synchronous and active high. After reset, every direction bit is 0, so `pin_oe` is all zero. `pin_out`, `irq_pin` and `irq_grp` are also zero.
- R2: A write to offset 0x00 sets the direction bits, and `pin_oe` equals the direction register from the clock edge that accepts the write. A direction bit of 1 means the pin drives.
- R3: At offset 0x14 a written 1 drives the matching output bit high. At 0x18 a written 1 drives it low. At 0x1C a written 1 inverts it. Written 0 bits leave outputs unchanged in all three cases.
- R4: A word write to offset 0x10 replaces the whole output register, and a read of 0x10 returns that register. Outputs do not change in cycles without a write.
- R5: Offset 0x04 holds a mask in which a 1 protects the bit. A write to 0x0C changes only the unprotected output bits. A read of 0x0C returns the synchronized pin level with protected bits forced to 0.
- R6: `bus_be[i]` enables bits 8i+7..8i. Bytes whose strobe is low are left unchanged by every kind of write, including set, clear and toggle.
- R7: A read of offset 0x08 returns the pin level two rising edges after `pin_in` changes. This holds whatever the direction of the pin.
- R8: In edge mode (mode bit 0), polarity bit 1 selects the rising edge and 0 selects the falling edge. An enabled edge sets the status bit on the third rising edge after the pin change. The bit stays set until a 1 is written to it at offset 0x2C.
- R9: In level mode (mode bit 1), polarity bit 1 selects active high. The status bit follows the pin with the same three-edge delay. Writing a 1 to clear it has no effect while the level is still active.
- R10: `irq_pin[i]` is status AND enable. A disabled pin raises no interrupt, and clearing the enable bit silences a pending flag.
- R11: With group control bit 0 = 0 (any mode), `irq_grp` is high when at least one enabled group pin equals its group polarity bit. It updates three rising edges after a pin change.
- R12: With group control bit 0 = 1 (all mode), `irq_grp` is high only when every enabled group pin matches. With no group pins enabled it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte write strobes |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| pin_in | input | WIDTH | Raw pin inputs |
| pin_out | output | WIDTH | Output data to pads |
| pin_oe | output | WIDTH | Output enables to pads |
| irq_pin | output | WIDTH | Per-pin interrupt requests |
| irq_grp | output | 1 | Group interrupt request |

## Verification
Register writes reach `pin_out` and `pin_oe` at the edge that accepts them, so the bench checks those outputs at the following falling edge. Reads are combinational and are sampled one time step after the address is driven. A change on `pin_in` becomes readable after two rising edges, and reaches `irq_pin` and `irq_grp` after three. The bench applies pin changes at a falling edge and checks the edge-interrupt timing at the first, second and third falling edges that follow. Group and level cases wait four edges before sampling, so that each level has settled.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int ADDR_W = 6;

    typedef enum logic [ADDR_W-1:0] {
        OFF_DIR   = 6'h00,
        OFF_MASK  = 6'h04,
        OFF_PIN   = 6'h08,
        OFF_MPORT = 6'h0C,
        OFF_PORT  = 6'h10,
        OFF_SET   = 6'h14,
        OFF_CLR   = 6'h18,
        OFF_TGL   = 6'h1C,
        OFF_IEN   = 6'h20,
        OFF_IMODE = 6'h24,
        OFF_IPOL  = 6'h28,
        OFF_ISTAT = 6'h2C,
        OFF_GEN   = 6'h30,
        OFF_GPOL  = 6'h34,
        OFF_GCTL  = 6'h38
    } reg_off_e;

    typedef enum logic {
        GRP_ANY = 1'b0,
        GRP_ALL = 1'b1
    } grp_mode_e;

    // One-hot write select, one field per writable register
    typedef struct packed {
        logic dir;
        logic mask;
        logic mport;
        logic port;
        logic set;
        logic clr;
        logic tgl;
        logic ien;
        logic imode;
        logic ipol;
        logic istat;
        logic gen;
        logic gpol;
        logic gctl;
    } wsel_t;

    // Expand byte strobes into a bit mask
    function automatic logic [DATA_W-1:0] strobe_bits(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < BE_W; b++) begin
            m[8*b +: 8] = {8{be[b]}};
        end
        return m;
    endfunction

    function automatic reg_off_e word_off(input logic [ADDR_W-1:0] addr);
        return reg_off_e'({addr[ADDR_W-1:2], 2'b00});
    endfunction

    function automatic wsel_t decode_write(input logic hit, input logic [ADDR_W-1:0] addr);
        wsel_t w;
        w = '0;
        if (hit) begin
            case (word_off(addr))
                OFF_DIR:   w.dir   = 1'b1;
                OFF_MASK:  w.mask  = 1'b1;
                OFF_MPORT: w.mport = 1'b1;
                OFF_PORT:  w.port  = 1'b1;
                OFF_SET:   w.set   = 1'b1;
                OFF_CLR:   w.clr   = 1'b1;
                OFF_TGL:   w.tgl   = 1'b1;
                OFF_IEN:   w.ien   = 1'b1;
                OFF_IMODE: w.imode = 1'b1;
                OFF_IPOL:  w.ipol  = 1'b1;
                OFF_ISTAT: w.istat = 1'b1;
                OFF_GEN:   w.gen   = 1'b1;
                OFF_GPOL:  w.gpol  = 1'b1;
                OFF_GCTL:  w.gctl  = 1'b1;
                default:   w       = '0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mgpio_pin_irq.sv
module mgpio_pin_irq #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,     // synchronized pin level
    input  logic [WIDTH-1:0] en,
    input  logic [WIDTH-1:0] mode,    // 1 = level, 0 = edge
    input  logic [WIDTH-1:0] pol,     // 1 = rising / high
    input  logic [WIDTH-1:0] clr_w1,  // write-one clear of edge flags
    output logic [WIDTH-1:0] stat,
    output logic [WIDTH-1:0] irq
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] stat_q;
    logic [WIDTH-1:0] stat_d;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic hit_edge;
            logic hit_level;
            assign hit_edge  = pol[i] ? (lvl[i] & ~prev_q[i]) : (~lvl[i] & prev_q[i]);
            assign hit_level = ~(lvl[i] ^ pol[i]);
            // Edge flags: new edge wins over a same-cycle clear
            assign stat_d[i] = mode[i] ? (en[i] & hit_level)
                                       : ((stat_q[i] & ~clr_w1[i]) | (en[i] & hit_edge));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= stat_d;
        end
    end

    assign stat = stat_q;
    assign irq  = stat_q & en;

endmodule

// File: rtl/mgpio_group_irq.sv
module mgpio_group_irq
    import mgpio_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] lvl,
    input  logic [WIDTH-1:0] en,
    input  logic [WIDTH-1:0] pol,
    input  grp_mode_e        mode,
    output logic             irq
);

    logic [WIDTH-1:0] match;
    logic             any_hit;
    logic             all_hit;
    logic             irq_q;

    assign match   = ~(lvl ^ pol);
    assign any_hit = |(en & match);
    assign all_hit = (|en) & (&(~en | match));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= (mode == GRP_ALL) ? all_hit : any_hit;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import mgpio_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  irq_pin,
    output logic              irq_grp
);

    wsel_t             we;
    logic [DATA_W-1:0] bm_full;
    logic [WIDTH-1:0]  bm;
    logic [WIDTH-1:0]  wd;

    logic [WIDTH-1:0]  dir_q, mask_q, port_q, port_d;
    logic [WIDTH-1:0]  ien_q, imode_q, ipol_q, gen_q, gpol_q;
    grp_mode_e         gctl_q;

    logic [WIDTH-1:0]  lvl;
    logic [WIDTH-1:0]  istat;
    logic [WIDTH-1:0]  clr_w1;

    assign we      = decode_write(bus_sel & bus_wr, bus_addr);
    assign bm_full = strobe_bits(bus_be);
    assign bm      = bm_full[WIDTH-1:0];
    assign wd      = bus_wdata[WIDTH-1:0];
    assign clr_w1  = we.istat ? (wd & bm) : '0;

    // Output data: whole/masked replacement first, then set, clear, toggle
    always_comb begin
        port_d = port_q;
        if (we.port)  port_d = (port_d & ~bm) | (wd & bm);
        if (we.mport) port_d = (port_d & ~(bm & ~mask_q)) | (wd & bm & ~mask_q);
        if (we.set)   port_d = port_d | (wd & bm);
        if (we.clr)   port_d = port_d & ~(wd & bm);
        if (we.tgl)   port_d = port_d ^ (wd & bm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            mask_q  <= '0;
            port_q  <= '0;
            ien_q   <= '0;
            imode_q <= '0;
            ipol_q  <= '0;
            gen_q   <= '0;
            gpol_q  <= '0;
            gctl_q  <= GRP_ANY;
        end else begin
            port_q <= port_d;
            if (we.dir)   dir_q   <= (dir_q   & ~bm) | (wd & bm);
            if (we.mask)  mask_q  <= (mask_q  & ~bm) | (wd & bm);
            if (we.ien)   ien_q   <= (ien_q   & ~bm) | (wd & bm);
            if (we.imode) imode_q <= (imode_q & ~bm) | (wd & bm);
            if (we.ipol)  ipol_q  <= (ipol_q  & ~bm) | (wd & bm);
            if (we.gen)   gen_q   <= (gen_q   & ~bm) | (wd & bm);
            if (we.gpol)  gpol_q  <= (gpol_q  & ~bm) | (wd & bm);
            if (we.gctl && bus_be[0]) gctl_q <= grp_mode_e'(bus_wdata[0]);
        end
    end

    mgpio_sync #(
        .WIDTH  (WIDTH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    mgpio_pin_irq #(
        .WIDTH (WIDTH)
    ) u_pin_irq (
        .clk    (clk),
        .rst    (rst),
        .lvl    (lvl),
        .en     (ien_q),
        .mode   (imode_q),
        .pol    (ipol_q),
        .clr_w1 (clr_w1),
        .stat   (istat),
        .irq    (irq_pin)
    );

    mgpio_group_irq #(
        .WIDTH (WIDTH)
    ) u_grp_irq (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .en   (gen_q),
        .pol  (gpol_q),
        .mode (gctl_q),
        .irq  (irq_grp)
    );

    // Single-cycle read path
    always_comb begin
        bus_rdata = '0;
        case (word_off(bus_addr))
            OFF_DIR:   bus_rdata[WIDTH-1:0] = dir_q;
            OFF_MASK:  bus_rdata[WIDTH-1:0] = mask_q;
            OFF_PIN:   bus_rdata[WIDTH-1:0] = lvl;
            OFF_MPORT: bus_rdata[WIDTH-1:0] = lvl & ~mask_q;
            OFF_PORT:  bus_rdata[WIDTH-1:0] = port_q;
            OFF_IEN:   bus_rdata[WIDTH-1:0] = ien_q;
            OFF_IMODE: bus_rdata[WIDTH-1:0] = imode_q;
            OFF_IPOL:  bus_rdata[WIDTH-1:0] = ipol_q;
            OFF_ISTAT: bus_rdata[WIDTH-1:0] = istat;
            OFF_GEN:   bus_rdata[WIDTH-1:0] = gen_q;
            OFF_GPOL:  bus_rdata[WIDTH-1:0] = gpol_q;
            OFF_GCTL:  bus_rdata[0]         = gctl_q;
            default:   bus_rdata            = '0;
        endcase
    end

    assign pin_out = port_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [5:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [3:0]       bus_be,
    input logic [WIDTH-1:0] pin_out,
    input logic [WIDTH-1:0] pin_oe,
    input logic [WIDTH-1:0] irq_pin,
    input logic             irq_grp,
    input logic [WIDTH-1:0] mask_q,
    input logic [WIDTH-1:0] gen_q
);

    logic [31:0]      strobe32;
    logic [WIDTH-1:0] sbits;
    logic [WIDTH-1:0] smask;
    logic             wr;

    always_comb begin
        for (int b = 0; b < 4; b++) begin
            strobe32[8*b +: 8] = bus_be[b] ? 8'hFF : 8'h00;
        end
    end

    assign smask = strobe32[WIDTH-1:0];
    assign sbits = bus_wdata[WIDTH-1:0] & smask;
    assign wr    = bus_sel && bus_wr;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && irq_pin == '0 && !irq_grp)); // R1

    AST_DIR_WORD: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == 6'h00 && bus_be == 4'hF) |=> (pin_oe == $past(bus_wdata[WIDTH-1:0]))); // R2

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == 6'h14) |=> ((pin_out & $past(sbits)) == $past(sbits))); // R3

    AST_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == 6'h18) |=> ((pin_out & $past(sbits)) == '0)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(pin_out)); // R4

    AST_MASK_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == 6'h0C) |=> (((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0)); // R5

    AST_BYTE_GUARD: assert property (@(posedge clk) disable iff (rst)
        (wr && bus_addr == 6'h10) |=> (((pin_out ^ $past(pin_out)) & ~$past(smask)) == '0)); // R6

    AST_GRP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (gen_q == '0 && !(wr && bus_addr == 6'h30)) |=> !irq_grp); // R12

endmodule

bind mgpio_port mgpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_pin   (irq_pin),
    .irq_grp   (irq_grp),
    .mask_q    (mask_q),
    .gen_q     (gen_q)
);

// File: tb/mgpio_port_bench.sv
`timescale 1ns/1ps
module mgpio_port_bench;

    localparam int W  = 32;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out, pin_oe, irq_pin;
    logic        irq_grp;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mgpio_port #(.WIDTH(W)) u_mgpio_port (
        .clk (clk), .rst (rst),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_be (bus_be), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe),
        .irq_pin (irq_pin), .irq_grp (irq_grp)
    );

    // Write vectors: address, strobes, data, expected pin_out and pin_oe after the write
    localparam logic [5:0]  V_ADDR [NV] = '{6'h00, 6'h10, 6'h14, 6'h18, 6'h1C, 6'h10, 6'h04,
                                            6'h0C, 6'h0C, 6'h14, 6'h00, 6'h1C, 6'h04, 6'h10};
    localparam logic [3:0]  V_BE   [NV] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'h1, 4'hF,
                                            4'hF, 4'hF, 4'hC, 4'h4, 4'h3, 4'hF, 4'hF};
    localparam logic [31:0] V_DATA [NV] = '{32'h0000FFFF, 32'h12345678, 32'h80000001, 32'h00000078,
                                            32'hFF000000, 32'hAAAAAAAA, 32'hFFFF0000, 32'h00000000,
                                            32'hFFFFFFFF, 32'h0000FFFF, 32'hFFFFFFFF, 32'h0000FFFF,
                                            32'h00000000, 32'h00000000};
    localparam logic [31:0] V_OUT  [NV] = '{32'h00000000, 32'h12345678, 32'h92345679, 32'h92345601,
                                            32'h6D345601, 32'h6D3456AA, 32'h6D3456AA, 32'h6D340000,
                                            32'h6D34FFFF, 32'h6D34FFFF, 32'h6D34FFFF, 32'h6D340000,
                                            32'h6D340000, 32'h00000000};
    localparam logic [31:0] V_OE   [NV] = '{32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF,
                                            32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF, 32'h0000FFFF,
                                            32'h0000FFFF, 32'h0000FFFF, 32'h00FFFFFF, 32'h00FFFFFF,
                                            32'h00FFFFFF, 32'h00FFFFFF};
    localparam string       V_REQ  [NV] = '{"R2", "R4", "R3", "R3", "R3", "R6", "R5",
                                            "R5", "R5", "R6", "R6", "R3", "R5", "R4"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        wait_edges(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", pin_oe, '0);
        chk("R1 out", pin_out, '0);
        chk("R1 irq", irq_pin, '0);
        chk("R1 grp", {31'b0, irq_grp}, '0);

        // Vector walk over write kinds (R2..R6)
        for (int i = 0; i < NV; i++) begin
            bus_write(V_ADDR[i], V_BE[i], V_DATA[i]);
            chk({V_REQ[i], " out"}, pin_out, V_OUT[i]);
            chk({V_REQ[i], " oe"}, pin_oe, V_OE[i]);
        end
        bus_read(6'h10, rd);
        chk("R4 data read", rd, 32'h0);
        bus_read(6'h00, rd);
        chk("R2 dir read", rd, 32'h00FFFFFF);

        // R7 pin level on inputs and outputs, R5 masked read
        bus_write(6'h00, 4'hF, 32'hFFFF0000);
        bus_write(6'h04, 4'hF, 32'hFFFF0000);
        @(negedge clk);
        pin_in = 32'hA5A50F0F;
        @(negedge clk);
        bus_read(6'h08, rd);       // one edge after change, read in the next cycle
        chk("R7 pin level", rd, 32'hA5A50F0F);
        bus_read(6'h0C, rd);
        chk("R5 masked read", rd, 32'h00000F0F);
        pin_in = '0;
        bus_write(6'h04, 4'hF, 32'h0);
        bus_write(6'h00, 4'hF, 32'h0);
        wait_edges(4);
        bus_read(6'h08, rd);
        chk("R7 pin level low", rd, 32'h0);

        // Pin interrupts: bit0 rising, bit1 falling, bit2 disabled, bit3 level high
        bus_write(6'h24, 4'hF, 32'h00000008);
        bus_write(6'h28, 4'hF, 32'h00000009);
        bus_write(6'h20, 4'hF, 32'h0000000B);
        pin_in[0] = 1'b1;
        @(negedge clk);
        chk("R8 rise edge1", {31'b0, irq_pin[0]}, 32'h0);
        @(negedge clk);
        chk("R8 rise edge2", {31'b0, irq_pin[0]}, 32'h0);
        @(negedge clk);
        chk("R8 rise edge3", {31'b0, irq_pin[0]}, 32'h1);
        pin_in[0] = 1'b0;
        wait_edges(4);
        chk("R8 sticky", {31'b0, irq_pin[0]}, 32'h1);
        bus_write(6'h2C, 4'hF, 32'h1);
        chk("R8 w1 clear", {31'b0, irq_pin[0]}, 32'h0);

        pin_in[1] = 1'b1;
        wait_edges(4);
        chk("R8 falling ignores rise", {31'b0, irq_pin[1]}, 32'h0);
        pin_in[1] = 1'b0;
        wait_edges(4);
        chk("R8 falling", {31'b0, irq_pin[1]}, 32'h1);
        bus_write(6'h2C, 4'hF, 32'h2);

        pin_in[2] = 1'b1;
        wait_edges(4);
        pin_in[2] = 1'b0;
        wait_edges(4);
        chk("R10 disabled pin", {31'b0, irq_pin[2]}, 32'h0);
        bus_read(6'h2C, rd);
        chk("R10 status clean", rd, 32'h0);

        pin_in[0] = 1'b1;
        wait_edges(4);
        bus_write(6'h20, 4'h1, 32'h0000000A);
        chk("R10 enable gates flag", {31'b0, irq_pin[0]}, 32'h0);
        pin_in[0] = 1'b0;

        pin_in[3] = 1'b1;
        wait_edges(2);
        chk("R9 level edge2", {31'b0, irq_pin[3]}, 32'h0);
        @(negedge clk);
        chk("R9 level edge3", {31'b0, irq_pin[3]}, 32'h1);
        bus_write(6'h2C, 4'hF, 32'h8);
        chk("R9 clear blocked", {31'b0, irq_pin[3]}, 32'h1);
        pin_in[3] = 1'b0;
        wait_edges(3);
        chk("R9 level drops", {31'b0, irq_pin[3]}, 32'h0);

        // Group interrupt on pins 8 (match high) and 9 (match low)
        pin_in = 32'h00000200;
        wait_edges(3);
        bus_write(6'h34, 4'hF, 32'h00000100);
        bus_write(6'h38, 4'hF, 32'h0);
        bus_write(6'h30, 4'hF, 32'h00000300);
        wait_edges(4);
        chk("R11 any none", {31'b0, irq_grp}, 32'h0);
        pin_in = 32'h00000300;
        wait_edges(4);
        chk("R11 any one", {31'b0, irq_grp}, 32'h1);
        bus_write(6'h38, 4'hF, 32'h1);
        wait_edges(4);
        chk("R12 all partial", {31'b0, irq_grp}, 32'h0);
        pin_in = 32'h00000100;
        wait_edges(4);
        chk("R12 all full", {31'b0, irq_grp}, 32'h1);
        bus_write(6'h30, 4'hF, 32'h0);
        wait_edges(4);
        chk("R12 all empty", {31'b0, irq_grp}, 32'h0);

        // R1 reset in mid-run
        bus_write(6'h00, 4'hF, 32'hFFFFFFFF);
        bus_write(6'h10, 4'hF, 32'h5A5A5A5A);
        rst = 1'b1;
        wait_edges(2);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 oe after reset", pin_oe, '0);
        chk("R1 out after reset", pin_out, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule